// File: doc/BRIEF.md
# Host-Target Mailbox Register Controller

This block gives a processor a pair of 64-bit mailbox words, one that carries requests to the host side and one that carries replies back. The processor's 32-bit register port reaches each word as two 32-bit halves, low half first. When the processor has written a complete request word, the block decodes three fields from it: an 8-bit device number, an 8-bit command and a 48-bit payload. It then acts on the request. It can raise a pass/fail exit report, send a console character through a valid/ready byte stream, or record a console read that a later received byte completes.

Every reply the block posts keeps bits 63:48 of the request that caused it and carries a 16-bit response in bits 15:0. Once a request has been handled, the block clears the request word to zero. Software polls for that zero before it issues the next request. A new request is accepted only while the request word is zero.

Top module: `hostlink_mbox`

## Requirements
- R1: After reset, every readable half reads zero, `exit_valid` and `fh_partial` are 0, `con_tx_valid` is 0, and the recorded console-read header is zero. A received byte then posts a reply whose bits 63:48 are zero.
- R2: The request word decodes as device = bits 63:56, command = bits 55:48 and payload = bits 47:0. Device 1 with command 1 sends payload bits 7:0 on the console output. It then posts the reply {request[63:48], 32'h0, 16'h0100 | byte} and clears the request word.
- R3: A write to the request low half (offset 8) loads bits 31:0 and arms the high half, but only while the request word is zero and no request is being processed. Otherwise the write changes nothing and disarms the high half.
- R4: A write to the request high half (offset 12) ORs the data into bits 63:32 and starts processing, but only while armed. An unarmed high write changes nothing.
- R5: While `con_tx_valid` is high and `con_tx_ready` is low, `con_tx_valid` stays high with stable data, and the request word stays nonzero and readable.
- R6: Device 0, command 0 with payload bit 0 set raises `exit_valid` and drives `exit_code` = payload >> 1, where 0 means pass. The request word keeps its value and no reply is posted. `exit_valid` stays high until reset.
- R7: Device 1, command 0 clears the request word without posting a reply and records request bits 63:48. A later `con_rx_valid` pulse posts {recorded bits, 32'h0, 16'h0100 | `con_rx_data`} one cycle later.
- R8: An unknown device, or an unknown command for device 0 or 1, posts {request[63:48], 48'h0} and clears the request word. A device 0, command 0 request with an even payload is treated the same way.
- R9: A processor write to the reply low half (offset 0) loads {32'h0, data} and sets `fh_partial`. A write to the reply high half (offset 4) ORs the data into bits 63:32 and clears `fh_partial`.
- R10: Reads return reply bits 31:0 at offset 0, reply bits 63:32 at offset 4, request bits 31:0 at offset 8 and request bits 63:32 at offset 12. Every other address reads zero.
- R11: When writes to the reply word collide in one cycle, a processor write wins over a command reply, and a command reply wins over a received byte. The losing update is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wen | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W (5) | Byte address of the 32-bit register access |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr` |
| con_tx_valid | output | 1 | Console output byte valid |
| con_tx_ready | input | 1 | Console output sink ready |
| con_tx_data | output | 8 | Console output byte |
| con_rx_valid | input | 1 | Received console byte strobe |
| con_rx_data | input | 8 | Received console byte |
| exit_valid | output | 1 | Sticky exit report flag |
| exit_code | output | 47 | Exit code, 0 means pass |
| fh_partial | output | 1 | Reply word half-written by the processor |

## Verification
A corrupted arm flag or request word shows up as a request that never triggers or that is accepted twice. The bench reads the request halves back one cycle after each write, so such a fault is visible at once. A wrong field decode or reply echo appears in the reply word on the cycle after processing starts, or as a console byte that is missing or extra. A pending-read header that is held wrongly appears only when the next byte is received. For that reason the bench checks the reply word directly after each receive pulse, and again after reset.

// File: rtl/hostlink_pkg.sv
package hostlink_pkg;
   localparam int WORD_W  = 64;
   localparam int BUS_W   = 32;
   localparam int DEV_W   = 8;
   localparam int CMD_W   = 8;
   localparam int PAY_W   = WORD_W - DEV_W - CMD_W;
   localparam int HDR_W   = DEV_W + CMD_W;
   localparam int RESP_W  = 16;
   localparam int EXIT_W  = PAY_W - 1;
   localparam int CHAR_W  = 8;

   localparam logic [DEV_W-1:0] DEV_SYSTEM  = 8'd0;
   localparam logic [DEV_W-1:0] DEV_CONSOLE = 8'd1;
   localparam logic [CMD_W-1:0] CMD_SYS     = 8'd0;
   localparam logic [CMD_W-1:0] CMD_GETC    = 8'd0;
   localparam logic [CMD_W-1:0] CMD_PUTC    = 8'd1;
   localparam logic [RESP_W-1:0] RESP_CHAR  = 16'h0100;

   typedef enum logic [1:0] {
      ACT_ZERO = 2'd0,
      ACT_PUTC = 2'd1,
      ACT_EXIT = 2'd2,
      ACT_GETC = 2'd3
   } act_e;

   function automatic act_e classify(input logic [DEV_W-1:0] dev,
                                     input logic [CMD_W-1:0] cmd,
                                     input logic             pay_lsb);
      act_e a;
      a = ACT_ZERO;
      if (dev == DEV_SYSTEM && cmd == CMD_SYS && pay_lsb) a = ACT_EXIT;
      else if (dev == DEV_CONSOLE && cmd == CMD_PUTC)     a = ACT_PUTC;
      else if (dev == DEV_CONSOLE && cmd == CMD_GETC)     a = ACT_GETC;
      return a;
   endfunction
endpackage

// File: rtl/hostlink_regdec.sv
module hostlink_regdec
   import hostlink_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int FH_OFFS = 0,
   parameter int TH_OFFS = 8,
   parameter bit RD_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wen,
   input  logic [ADDR_W-1:0]   addr,
   input  logic [WORD_W-1:0]   fh_word,
   input  logic [WORD_W-1:0]   th_word,
   output logic                wr_fh_lo,
   output logic                wr_fh_hi,
   output logic                wr_th_lo,
   output logic                wr_th_hi,
   output logic [BUS_W-1:0]    rdata
);
   localparam int HALF_B = BUS_W / 8;
   localparam logic [ADDR_W-1:0] A_FH_LO = ADDR_W'(FH_OFFS);
   localparam logic [ADDR_W-1:0] A_FH_HI = ADDR_W'(FH_OFFS + HALF_B);
   localparam logic [ADDR_W-1:0] A_TH_LO = ADDR_W'(TH_OFFS);
   localparam logic [ADDR_W-1:0] A_TH_HI = ADDR_W'(TH_OFFS + HALF_B);

   logic [BUS_W-1:0] rd_mux;

   assign wr_fh_lo = wen && (addr == A_FH_LO);
   assign wr_fh_hi = wen && (addr == A_FH_HI);
   assign wr_th_lo = wen && (addr == A_TH_LO);
   assign wr_th_hi = wen && (addr == A_TH_HI);

   always_comb begin
      rd_mux = '0;
      if      (addr == A_FH_LO) rd_mux = fh_word[BUS_W-1:0];
      else if (addr == A_FH_HI) rd_mux = fh_word[WORD_W-1:BUS_W];
      else if (addr == A_TH_LO) rd_mux = th_word[BUS_W-1:0];
      else if (addr == A_TH_HI) rd_mux = th_word[WORD_W-1:BUS_W];
   end

   generate
      if (RD_REG) begin : g_rd_flop
         logic [BUS_W-1:0] rd_q;
         always_ff @(posedge clk) begin
            if (!rst_n) rd_q <= '0;
            else        rd_q <= rd_mux;
         end
         assign rdata = rd_q;
      end else begin : g_rd_comb
         assign rdata = rd_mux;
      end
   endgenerate
endmodule

// File: rtl/hostlink_exec.sv
module hostlink_exec
   import hostlink_pkg::*;
(
   input  logic               busy,
   input  logic [WORD_W-1:0]  req,
   input  logic               tx_ready,
   output act_e               act,
   output logic               done,
   output logic               reply_en,
   output logic [RESP_W-1:0]  reply,
   output logic               tx_valid,
   output logic [CHAR_W-1:0]  tx_data
);
   logic [DEV_W-1:0] dev;
   logic [CMD_W-1:0] cmd;
   logic [PAY_W-1:0] pay;

   assign dev = req[WORD_W-1 -: DEV_W];
   assign cmd = req[PAY_W +: CMD_W];
   assign pay = req[PAY_W-1:0];
   assign act = classify(dev, cmd, pay[0]);

   assign tx_valid = busy && (act == ACT_PUTC);
   assign tx_data  = pay[CHAR_W-1:0];
   assign done     = busy && ((act != ACT_PUTC) || tx_ready);
   assign reply_en = (act == ACT_PUTC) || (act == ACT_ZERO);
   assign reply    = (act == ACT_PUTC) ? (RESP_CHAR | RESP_W'(pay[CHAR_W-1:0])) : '0;
endmodule

// File: rtl/hostlink_mbox.sv
module hostlink_mbox
   import hostlink_pkg::*;
#(
   parameter int ADDR_W  = 5,
   parameter int FH_OFFS = 0,
   parameter int TH_OFFS = 8,
   parameter bit RD_REG  = 1'b0
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                reg_wen,
   input  logic [ADDR_W-1:0]   reg_addr,
   input  logic [31:0]         reg_wdata,
   output logic [31:0]         reg_rdata,
   output logic                con_tx_valid,
   input  logic                con_tx_ready,
   output logic [7:0]          con_tx_data,
   input  logic                con_rx_valid,
   input  logic [7:0]          con_rx_data,
   output logic                exit_valid,
   output logic [46:0]         exit_code,
   output logic                fh_partial
);
   localparam int SPAN = 2 * (BUS_W / 8);

   generate
      if (WORD_W != 2 * BUS_W) begin : g_bad_word
         $error("request word must be two bus halves");
      end
      if ((FH_OFFS % SPAN) != 0 || (TH_OFFS % SPAN) != 0) begin : g_bad_align
         $error("mailbox offsets must be word aligned");
      end
      if (FH_OFFS == TH_OFFS) begin : g_bad_overlap
         $error("mailbox offsets must differ");
      end
      if ((1 << ADDR_W) < FH_OFFS + SPAN || (1 << ADDR_W) < TH_OFFS + SPAN) begin : g_bad_addr
         $error("address width too small for offsets");
      end
   endgenerate

   logic [WORD_W-1:0] th_q, fh_q;
   logic              armed_q, busy_q, part_q, exit_q;
   logic [HDR_W-1:0]  pread_q;
   logic [EXIT_W-1:0] code_q;

   logic wr_fh_lo, wr_fh_hi, wr_th_lo, wr_th_hi;
   act_e act;
   logic done, reply_en;
   logic [RESP_W-1:0] reply;

   hostlink_regdec #(
      .ADDR_W(ADDR_W), .FH_OFFS(FH_OFFS), .TH_OFFS(TH_OFFS), .RD_REG(RD_REG)
   ) u_dec (
      .clk(clk), .rst_n(rst_n), .wen(reg_wen), .addr(reg_addr),
      .fh_word(fh_q), .th_word(th_q),
      .wr_fh_lo(wr_fh_lo), .wr_fh_hi(wr_fh_hi),
      .wr_th_lo(wr_th_lo), .wr_th_hi(wr_th_hi),
      .rdata(reg_rdata)
   );

   hostlink_exec u_exec (
      .busy(busy_q), .req(th_q), .tx_ready(con_tx_ready),
      .act(act), .done(done), .reply_en(reply_en), .reply(reply),
      .tx_valid(con_tx_valid), .tx_data(con_tx_data)
   );

   // request word, arm flag, processing flag, exit report
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         th_q    <= '0;
         armed_q <= 1'b0;
         busy_q  <= 1'b0;
         pread_q <= '0;
         exit_q  <= 1'b0;
         code_q  <= '0;
      end else begin
         if (wr_th_lo) begin
            if (th_q == '0 && !busy_q) begin
               th_q[BUS_W-1:0] <= reg_wdata;
               armed_q         <= 1'b1;
            end else begin
               armed_q <= 1'b0;
            end
         end else if (wr_th_hi && armed_q) begin
            th_q[WORD_W-1:BUS_W] <= th_q[WORD_W-1:BUS_W] | reg_wdata;
            armed_q              <= 1'b0;
            busy_q               <= 1'b1;
         end
         if (done) begin
            busy_q <= 1'b0;
            if (act != ACT_EXIT) th_q <= '0;
            if (act == ACT_GETC) pread_q <= th_q[WORD_W-1 -: HDR_W];
            if (act == ACT_EXIT) begin
               exit_q <= 1'b1;
               code_q <= th_q[PAY_W-1:1];
            end
         end
      end
   end

   // reply word: processor write > command reply > received byte
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         fh_q   <= '0;
         part_q <= 1'b0;
      end else if (wr_fh_lo) begin
         fh_q   <= {{(WORD_W-BUS_W){1'b0}}, reg_wdata};
         part_q <= 1'b1;
      end else if (wr_fh_hi) begin
         fh_q[WORD_W-1:BUS_W] <= fh_q[WORD_W-1:BUS_W] | reg_wdata;
         part_q               <= 1'b0;
      end else if (done && reply_en) begin
         fh_q <= {th_q[WORD_W-1 -: HDR_W], {(WORD_W-HDR_W-RESP_W){1'b0}}, reply};
      end else if (con_rx_valid) begin
         fh_q <= {pread_q, {(WORD_W-HDR_W-RESP_W){1'b0}}, RESP_CHAR | RESP_W'(con_rx_data)};
      end
   end

   assign exit_valid = exit_q;
   assign exit_code  = code_q;
   assign fh_partial = part_q;
endmodule

// File: rtl/hostlink_mbox_chk.sv
module hostlink_mbox_chk (
   input logic        clk,
   input logic        rst_n,
   input logic        wr_th_lo,
   input logic        wr_fh_lo,
   input logic        busy_q,
   input logic [63:0] th_q,
   input logic [63:0] fh_q,
   input logic [31:0] reg_wdata,
   input logic        con_tx_valid,
   input logic        con_tx_ready,
   input logic [7:0]  con_tx_data,
   input logic        exit_valid,
   input logic [46:0] exit_code,
   input logic        fh_partial
);
   // R3: a low-half request write while the word is occupied leaves it unchanged
   p_th_reject_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_th_lo && (th_q != 64'h0 || busy_q)) |=> $stable(th_q));

   // R5: a stalled console byte is held
   p_tx_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (con_tx_valid && !con_tx_ready) |=> (con_tx_valid && $stable(con_tx_data) && th_q != 64'h0));

   // R6: exit report is sticky and its code frozen
   p_exit_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      exit_valid |=> (exit_valid && $stable(exit_code)));

   // R9: low reply write zeroes the high half and marks the partial update
   p_fh_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
      wr_fh_lo |=> (fh_partial && fh_q == {32'h0, $past(reg_wdata)}));

   // R2: console output only for a device 1 / command 1 request
   p_tx_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
      con_tx_valid |-> (th_q[63:48] == 16'h0101));
endmodule

bind hostlink_mbox hostlink_mbox_chk u_chk (
   .clk(clk), .rst_n(rst_n), .wr_th_lo(wr_th_lo), .wr_fh_lo(wr_fh_lo),
   .busy_q(busy_q), .th_q(th_q), .fh_q(fh_q), .reg_wdata(reg_wdata),
   .con_tx_valid(con_tx_valid), .con_tx_ready(con_tx_ready),
   .con_tx_data(con_tx_data), .exit_valid(exit_valid),
   .exit_code(exit_code), .fh_partial(fh_partial)
);

// File: tb/test_hostlink_mbox.sv
`timescale 1ns/1ps
module test_hostlink_mbox;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wen = 1'b0;
   logic [4:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        con_tx_valid;
   logic        con_tx_ready = 1'b1;
   logic [7:0]  con_tx_data;
   logic        con_rx_valid = 1'b0;
   logic [7:0]  con_rx_data = '0;
   logic        exit_valid;
   logic [46:0] exit_code;
   logic        fh_partial;

   int n_chk = 0, n_fail = 0, n_ch = 0;
   logic [7:0] last_ch = '0;
   bit finished = 0;

   always #2 clk = ~clk;

   hostlink_mbox i_hostlink_mbox (
      .clk(clk), .rst_n(rst_n), .reg_wen(reg_wen), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
      .con_tx_valid(con_tx_valid), .con_tx_ready(con_tx_ready), .con_tx_data(con_tx_data),
      .con_rx_valid(con_rx_valid), .con_rx_data(con_rx_data),
      .exit_valid(exit_valid), .exit_code(exit_code), .fh_partial(fh_partial)
   );

   always @(posedge clk) if (con_tx_valid && con_tx_ready) begin
      last_ch = con_tx_data;
      n_ch++;
   end

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      reg_wen = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wen = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      reg_addr = a;
      #0.5;
      d = reg_rdata;
   endtask

   task automatic rd64(input logic [4:0] a, output logic [63:0] d);
      logic [31:0] lo, hi;
      rd(a, lo);
      rd(a + 5'd4, hi);
      d = {hi, lo};
   endtask

   task automatic send(input logic [63:0] w);
      wr(5'd8, w[31:0]);
      wr(5'd12, w[63:32]);
      @(negedge clk);
   endtask

   task automatic rx(input logic [7:0] c);
      con_rx_valid = 1'b1; con_rx_data = c;
      @(negedge clk);
      con_rx_valid = 1'b0;
   endtask

   // vector table: request word, expected reply word, expected console byte (bit 8 = byte expected)
   localparam int NV = 6;
   localparam logic [63:0] V_REQ [NV] = '{
      64'h0101_0000_0000_0041, 64'h0101_0000_1234_56FF, 64'h0700_0000_0000_0005,
      64'h0105_0000_0000_0033, 64'h0003_0000_0000_0001, 64'h0000_0000_ABCD_0000};
   localparam logic [63:0] V_FH [NV] = '{
      64'h0101_0000_0000_0141, 64'h0101_0000_0000_01FF, 64'h0700_0000_0000_0000,
      64'h0105_0000_0000_0000, 64'h0003_0000_0000_0000, 64'h0000_0000_0000_0000};
   localparam logic [8:0] V_CH [NV] = '{9'h141, 9'h1FF, 9'h000, 9'h000, 9'h000, 9'h000};

   initial begin
      repeat (100000) @(posedge clk);
      if (!finished) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      logic [63:0] v;
      logic [31:0] d;
      int c0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd64(5'd0, v);  chk(v == 0, "R1 reply after reset", v, 0);
      rd64(5'd8, v);  chk(v == 0, "R1 request after reset", v, 0);
      chk(!exit_valid && !fh_partial && !con_tx_valid, "R1 outputs after reset",
          {exit_valid, fh_partial, con_tx_valid}, 0);

      // R2 R8 vector table
      for (int i = 0; i < NV; i++) begin
         c0 = n_ch;
         send(V_REQ[i]);
         rd64(5'd0, v);
         chk(v == V_FH[i], (V_CH[i][8] ? "R2 putc reply" : "R8 zero reply"), v, V_FH[i]);
         rd64(5'd8, v);
         chk(v == 0, "R2 R8 request cleared", v, 0);
         if (V_CH[i][8])
            chk(n_ch == c0 + 1 && last_ch == V_CH[i][7:0], "R2 console byte", {n_ch, last_ch}, {c0 + 1, V_CH[i][7:0]});
         else
            chk(n_ch == c0, "R8 no console byte", n_ch, c0);
      end

      // R4 unarmed high write ignored
      wr(5'd12, 32'h0101_0000);
      rd64(5'd8, v); chk(v == 0, "R4 unarmed high write", v, 0);
      chk(!con_tx_valid, "R4 no processing", con_tx_valid, 0);

      // R5 R3 stall, rejection while occupied
      con_tx_ready = 1'b0;
      c0 = n_ch;
      send(64'h0101_0000_0000_0042);
      chk(con_tx_valid && con_tx_data == 8'h42, "R5 byte held", {con_tx_valid, con_tx_data}, 9'h142);
      wr(5'd8, 32'h0000_0099);
      rd(5'd8, d); chk(d == 32'h42, "R3 low write rejected", d, 32'h42);
      wr(5'd12, 32'h0000_0055);
      rd(5'd12, d); chk(d == 32'h0101_0000, "R4 disarmed high write", d, 32'h0101_0000);
      repeat (3) @(negedge clk);
      chk(con_tx_valid && n_ch == c0, "R5 still stalled", {con_tx_valid, n_ch}, {1'b1, c0});
      con_tx_ready = 1'b1;
      @(negedge clk);
      rd64(5'd0, v); chk(v == 64'h0101_0000_0000_0142, "R5 reply after stall", v, 64'h0101_0000_0000_0142);
      rd64(5'd8, v); chk(v == 0, "R5 request cleared after stall", v, 0);
      chk(n_ch == c0 + 1 && last_ch == 8'h42, "R5 one byte sent", n_ch, c0 + 1);

      // R7 console read
      send(64'h0100_0000_0000_0000);
      rd64(5'd0, v); chk(v == 64'h0101_0000_0000_0142, "R7 no reply on read request", v, 64'h0101_0000_0000_0142);
      rd64(5'd8, v); chk(v == 0, "R7 request cleared", v, 0);
      rx(8'h7A);
      rd64(5'd0, v); chk(v == 64'h0100_0000_0000_017A, "R7 received byte reply", v, 64'h0100_0000_0000_017A);

      // R11 processor write beats received byte
      reg_wen = 1'b1; reg_addr = 5'd0; reg_wdata = 32'h0000_5A5A;
      con_rx_valid = 1'b1; con_rx_data = 8'h33;
      @(negedge clk);
      reg_wen = 1'b0; con_rx_valid = 1'b0;
      rd64(5'd0, v); chk(v == 64'h5A5A, "R11 processor write wins", v, 64'h5A5A);

      // R9 reply halves
      chk(fh_partial, "R9 partial set", fh_partial, 1);
      wr(5'd4, 32'h12);
      chk(!fh_partial, "R9 partial cleared", fh_partial, 0);
      wr(5'd4, 32'h100);
      rd(5'd4, d); chk(d == 32'h112, "R9 high half OR", d, 32'h112);

      // R10 other addresses
      rd(5'd1, d);  chk(d == 0, "R10 misaligned read", d, 0);
      rd(5'd16, d); chk(d == 0, "R10 unmapped read", d, 0);
      rd(5'd0, d);  chk(d == 32'h5A5A, "R10 reply low read", d, 32'h5A5A);

      // R6 exit fail code
      send(64'h0000_0000_0000_000B);
      chk(exit_valid && exit_code == 47'd5, "R6 exit code", {exit_valid, exit_code}, {1'b1, 47'd5});
      rd64(5'd8, v); chk(v == 64'hB, "R6 request kept", v, 64'hB);
      rd64(5'd0, v); chk(v == 64'h0000_0112_0000_5A5A, "R6 no reply", v, 64'h0000_0112_0000_5A5A);
      repeat (5) @(negedge clk);
      chk(exit_valid, "R6 exit sticky", exit_valid, 1);

      // R1 reset clears everything including recorded read header
      rst_n = 1'b0;
      repeat (2) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(!exit_valid, "R1 exit cleared by reset", exit_valid, 0);
      rd64(5'd8, v); chk(v == 0, "R1 request cleared by reset", v, 0);
      rx(8'h41);
      rd64(5'd0, v); chk(v == 64'h141, "R1 read header cleared", v, 64'h141);

      // R6 exit pass
      send(64'h0000_0000_0000_0001);
      chk(exit_valid && exit_code == 0, "R6 exit pass", {exit_valid, exit_code}, {1'b1, 47'd0});

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule